// File: doc/BRIEF.md
# DRAM Row Refresh Scheduler

This block keeps a DRAM array alive by refreshing its rows one at a time. An interval timer raises a refresh request every `INTERVAL_CYC` clock cycles. The chosen interval is the retention period divided by the row count: a 50 ms retention window over 16384 rows gives one row about every 3.05 us. Each refresh slot holds the array for `REF_CYC` cycles, which corresponds to 100 ns. Over a full pass this takes about 1.64 ms of every 50 ms, roughly 3.3 % of the array's time. During that time the access port receives no grant.

The scheduler shares the array between refresh and a single access requester that uses a request/grant handshake. The requester raises `acc_req` and keeps it high for as long as its access lasts. `acc_gnt` stays high while that access runs. An access that has already been granted is never cut short. A refresh that becomes due during an access is owed and starts the cycle after the requester lets go. If several intervals pass while refresh is held off, a saturating owed-refresh count records each one. The owed refreshes are then issued back to back. While any refresh is owed, it wins over a new request.

The controller has three named states. `ST_IDLE` means nothing is running. `ST_ACCESS` means the requester holds the grant. `ST_REFRESH` means a row refresh slot is in progress. The transitions are:
- IDLE to REFRESH when a refresh is owed.
- IDLE to ACCESS on a request when nothing is owed.
- ACCESS to REFRESH when the request drops and a refresh is owed.
- ACCESS to IDLE when the request drops and nothing is owed.
- REFRESH to REFRESH at the end of a slot when more refreshes are owed.
- REFRESH to ACCESS at the end of a slot when nothing more is owed and a request is waiting.
- REFRESH to IDLE at the end of a slot otherwise.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is asserted and after its release, `ref_busy`, `ref_cmd` and `acc_gnt` are 0 and `ref_row` is 0.
- R2: With the access port quiet, a refresh slot begins `INTERVAL_CYC`+1 clock edges after reset release, and a new one begins every `INTERVAL_CYC` edges after that.
- R3: `ref_busy` stays high for exactly `REF_CYC` consecutive cycles per row, and `ref_cmd` is a one-cycle pulse in the first cycle of each slot.
- R4: `ref_row` holds steady through a slot, is one higher after the slot ends, and wraps from `ROWS`-1 to 0.
- R5: `acc_gnt` and `ref_busy` are never high together, and `acc_gnt` is high only if `acc_req` was high at the previous edge.
- R6: A refresh that falls due during a granted access waits until `acc_req` drops. The slot starts at the first edge at which the request is seen low.
- R7: When a refresh is owed and `acc_req` is high in `ST_IDLE`, the refresh goes first. The waiting request is granted in the cycle right after the slot ends.
- R8: Refreshes owed from several elapsed intervals run back to back. A new `ref_cmd` comes in the cycle after the previous slot ends, with no idle cycle between.
- R9: With nothing owed, a request seen in `ST_IDLE` is granted from the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_req | input | 1 | Access request, held high for the length of the access |
| acc_gnt | output | 1 | Access grant, high while the access owns the array |
| ref_cmd | output | 1 | One-cycle pulse that starts a row refresh |
| ref_row | output | $clog2(ROWS) | Row being refreshed |
| ref_busy | output | 1 | High during each refresh slot |

## Verification
The bench builds the scheduler with `ROWS` = 8, `INTERVAL_CYC` = 20, `REF_CYC` = 3 and `DEBT_W` = 3. With these values the row counter wraps after eight refreshes. The test also holds one access open across three intervals, so three refreshes are owed and drained back to back, and all of this fits in under two hundred cycles. The short slot keeps the busy-length, priority and handover edges easy to place in cycle-exact expected vectors.

// File: rtl/refresh_pkg.sv
package refresh_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACCESS  = 2'd1,
        ST_REFRESH = 2'd2
    } sched_state_t;

endpackage

// File: rtl/refresh_interval_timer.sv
// Free-running interval timer: one tick every INTERVAL_CYC cycles.
module refresh_interval_timer #(
    parameter int INTERVAL_CYC = 381
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (INTERVAL_CYC > 1) ? $clog2(INTERVAL_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(INTERVAL_CYC - 1);

    logic [CW-1:0] cnt;

    assign tick_o = (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (tick_o) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/refresh_debt_counter.sv
// Saturating count of refreshes that are due but not yet performed.
module refresh_debt_counter #(
    parameter int DEBT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc_i,
    input  logic dec_i,
    output logic pending_o,
    output logic more_o
);
    localparam logic [DEBT_W-1:0] MAXV = {DEBT_W{1'b1}};
    localparam logic [DEBT_W-1:0] ONE  = DEBT_W'(1);

    logic [DEBT_W-1:0] owed;

    assign pending_o = (owed != '0);
    // Still owed after the slot that completes this cycle.
    assign more_o    = (owed > ONE) || inc_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            owed <= '0;
        end else begin
            unique case ({inc_i, dec_i})
                2'b10:   if (owed != MAXV) owed <= owed + 1'b1;
                2'b01:   owed <= owed - 1'b1;
                default: owed <= owed;
            endcase
        end
    end
endmodule

// File: rtl/refresh_row_counter.sv
// Row address pointer, wraps after ROWS-1.
module refresh_row_counter #(
    parameter int ROWS = 16384
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    adv_i,
    output logic [$clog2(ROWS)-1:0] row_o
);
    localparam int ROW_W = $clog2(ROWS);
    localparam logic [ROW_W-1:0] LAST = ROW_W'(ROWS - 1);

    logic [ROW_W-1:0] row_succ;

    generate
        if (ROWS == (1 << ROW_W)) begin : g_pow2
            assign row_succ = row_o + 1'b1;
        end else begin : g_mod
            assign row_succ = (row_o == LAST) ? '0 : row_o + 1'b1;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_o <= '0;
        end else if (adv_i) begin
            row_o <= row_succ;
        end
    end
endmodule

// File: rtl/refresh_sched_fsm.sv
// Arbitration state machine between refresh slots and the access port.
module refresh_sched_fsm
    import refresh_pkg::*;
#(
    parameter int REF_CYC = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic acc_req_i,
    input  logic pending_i,
    input  logic more_i,
    output logic acc_gnt_o,
    output logic ref_busy_o,
    output logic ref_cmd_o,
    output logic done_o
);
    localparam int DW = $clog2(REF_CYC + 1);
    localparam logic [DW-1:0] DLAST = DW'(REF_CYC - 1);

    sched_state_t state, state_nx;
    logic [DW-1:0] dur;

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (pending_i)      state_nx = ST_REFRESH;
                else if (acc_req_i) state_nx = ST_ACCESS;
            end
            ST_ACCESS: begin
                if (!acc_req_i)     state_nx = pending_i ? ST_REFRESH : ST_IDLE;
            end
            ST_REFRESH: begin
                if (dur == DLAST) begin
                    if (more_i)         state_nx = ST_REFRESH;
                    else if (acc_req_i) state_nx = ST_ACCESS;
                    else                state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register and slot length counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            dur   <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_REFRESH && dur != DLAST) dur <= dur + 1'b1;
            else                                     dur <= '0;
        end
    end

    // Outputs
    always_comb begin
        acc_gnt_o  = 1'b0;
        ref_busy_o = 1'b0;
        ref_cmd_o  = 1'b0;
        done_o     = 1'b0;
        unique case (state)
            ST_IDLE:   ;
            ST_ACCESS: acc_gnt_o = 1'b1;
            ST_REFRESH: begin
                ref_busy_o = 1'b1;
                ref_cmd_o  = (dur == '0);
                done_o     = (dur == DLAST);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
    parameter int ROWS         = 16384,
    parameter int INTERVAL_CYC = 381,
    parameter int REF_CYC      = 13,
    parameter int DEBT_W       = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    acc_req,
    output logic                    acc_gnt,
    output logic                    ref_cmd,
    output logic [$clog2(ROWS)-1:0] ref_row,
    output logic                    ref_busy
);
    logic tick, pending, more, done;

    refresh_interval_timer #(.INTERVAL_CYC(INTERVAL_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .tick_o(tick)
    );

    refresh_debt_counter #(.DEBT_W(DEBT_W)) u_debt (
        .clk(clk), .rst_n(rst_n), .inc_i(tick), .dec_i(done),
        .pending_o(pending), .more_o(more)
    );

    refresh_row_counter #(.ROWS(ROWS)) u_row (
        .clk(clk), .rst_n(rst_n), .adv_i(done), .row_o(ref_row)
    );

    refresh_sched_fsm #(.REF_CYC(REF_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .acc_req_i(acc_req),
        .pending_i(pending), .more_i(more),
        .acc_gnt_o(acc_gnt), .ref_busy_o(ref_busy),
        .ref_cmd_o(ref_cmd), .done_o(done)
    );
endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
    parameter int ROWS    = 16384,
    parameter int REF_CYC = 13
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    acc_req,
    input logic                    acc_gnt,
    input logic                    ref_cmd,
    input logic [$clog2(ROWS)-1:0] ref_row,
    input logic                    ref_busy
);
    localparam int ROW_W = $clog2(ROWS);

    logic [15:0]      run_len;
    logic [ROW_W-1:0] row_succ;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len  <= '0;
            row_succ <= '0;
        end else begin
            if (ref_cmd)       run_len <= 16'd1;
            else if (ref_busy) run_len <= run_len + 16'd1;
            row_succ <= (ref_row == ROW_W'(ROWS - 1)) ? '0 : ref_row + 1'b1;
        end
    end

    AST_GNT_BUSY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_gnt && ref_busy)); // R5
    AST_GNT_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        acc_gnt |-> $past(acc_req)); // R5
    AST_CMD_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        ref_cmd |-> ref_busy); // R3
    AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ref_cmd |=> !ref_cmd); // R3
    AST_SLOT_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        ((!ref_busy || ref_cmd) && $past(ref_busy)) |-> (run_len == 16'(REF_CYC))); // R3
    AST_ROW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_busy && !ref_cmd) |-> $stable(ref_row)); // R4
    AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ((!ref_busy || ref_cmd) && $past(ref_busy)) |-> (ref_row == row_succ)); // R4
endmodule

bind dram_refresh_sched refresh_sched_chk #(.ROWS(ROWS), .REF_CYC(REF_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_gnt(acc_gnt),
    .ref_cmd(ref_cmd), .ref_row(ref_row), .ref_busy(ref_busy)
);

// File: tb/test_dram_refresh_sched.sv
`timescale 1ns/1ps
module test_dram_refresh_sched;
    localparam int ROWS = 8, INTERVAL_CYC = 20, REF_CYC = 3, DEBT_W = 3;

    typedef struct packed {
        logic [15:0] at_edge;
        logic        req;   // acc_req driven after sampling
        logic        busy;
        logic        gnt;
        logic        cmd;
        logic [2:0]  row;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t TAB [NV] = '{
        '{16'd21,  1'b0, 1'b1, 1'b0, 1'b1, 3'd0}, // R2 first slot
        '{16'd23,  1'b0, 1'b1, 1'b0, 1'b0, 3'd0}, // R3 last busy cycle
        '{16'd24,  1'b0, 1'b0, 1'b0, 1'b0, 3'd1}, // R3 R4 slot over, row steps
        '{16'd25,  1'b1, 1'b0, 1'b0, 1'b0, 3'd1},
        '{16'd26,  1'b1, 1'b0, 1'b1, 1'b0, 3'd1}, // R9 grant next edge
        '{16'd41,  1'b1, 1'b0, 1'b1, 1'b0, 3'd1}, // R6 refresh held off
        '{16'd44,  1'b0, 1'b0, 1'b1, 1'b0, 3'd1}, // R6
        '{16'd45,  1'b0, 1'b1, 1'b0, 1'b1, 3'd1}, // R6 slot after release
        '{16'd47,  1'b0, 1'b1, 1'b0, 1'b0, 3'd1},
        '{16'd48,  1'b0, 1'b0, 1'b0, 1'b0, 3'd2},
        '{16'd60,  1'b1, 1'b0, 1'b0, 1'b0, 3'd2},
        '{16'd61,  1'b1, 1'b1, 1'b0, 1'b1, 3'd2}, // R7 refresh wins
        '{16'd63,  1'b1, 1'b1, 1'b0, 1'b0, 3'd2}, // R7
        '{16'd64,  1'b1, 1'b0, 1'b1, 1'b0, 3'd3}, // R7 grant right after
        '{16'd100, 1'b1, 1'b0, 1'b1, 1'b0, 3'd3}, // R6 debt builds
        '{16'd125, 1'b0, 1'b0, 1'b1, 1'b0, 3'd3},
        '{16'd126, 1'b0, 1'b1, 1'b0, 1'b1, 3'd3}, // R8 first owed
        '{16'd128, 1'b0, 1'b1, 1'b0, 1'b0, 3'd3},
        '{16'd129, 1'b0, 1'b1, 1'b0, 1'b1, 3'd4}, // R8 back to back
        '{16'd132, 1'b0, 1'b1, 1'b0, 1'b1, 3'd5}, // R8 third
        '{16'd134, 1'b0, 1'b1, 1'b0, 1'b0, 3'd5},
        '{16'd135, 1'b0, 1'b0, 1'b0, 1'b0, 3'd6}, // R8 drained
        '{16'd161, 1'b0, 1'b1, 1'b0, 1'b1, 3'd7}, // R2 periodic
        '{16'd164, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0}  // R4 wrap
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       acc_req;
    logic       acc_gnt, ref_cmd, ref_busy;
    logic [2:0] ref_row;
    int         edge_n;
    int         n_cmp = 0;
    int         n_bad = 0;

    always #4 clk = ~clk;

    always @(posedge clk) edge_n <= rst_n ? edge_n + 1 : 0;

    dram_refresh_sched #(.ROWS(ROWS), .INTERVAL_CYC(INTERVAL_CYC),
                         .REF_CYC(REF_CYC), .DEBT_W(DEBT_W)) i_dram_refresh_sched (
        .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_gnt(acc_gnt),
        .ref_cmd(ref_cmd), .ref_row(ref_row), .ref_busy(ref_busy)
    );

    task automatic chk(input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic wait_edge(input int e);
        while (edge_n != e) @(negedge clk);
    endtask

    initial begin
        #(8 * 20000);
        n_bad++;
        $display("FAIL watchdog expired (all requirements)");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int busy_cyc, cmd_cnt;
        rst_n   = 1'b0;
        acc_req = 1'b0;
        edge_n  = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy in reset", ref_busy, 0);
        chk("R1 gnt in reset",  acc_gnt, 0);
        chk("R1 cmd in reset",  ref_cmd, 0);
        chk("R1 row in reset",  ref_row, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy after release", ref_busy, 0);
        chk("R1 row after release",  ref_row, 0);

        for (int i = 0; i < NV; i++) begin
            wait_edge(int'(TAB[i].at_edge));
            chk($sformatf("R3/R2 busy @%0d", TAB[i].at_edge), ref_busy, TAB[i].busy);
            chk($sformatf("R5/R6/R7/R9 gnt @%0d", TAB[i].at_edge), acc_gnt, TAB[i].gnt);
            chk($sformatf("R3/R8 cmd @%0d", TAB[i].at_edge), ref_cmd, TAB[i].cmd);
            chk($sformatf("R4 row @%0d", TAB[i].at_edge), ref_row, TAB[i].row);
            chk($sformatf("R5 exclusive @%0d", TAB[i].at_edge),
                int'(acc_gnt && ref_busy), 0);
            acc_req = TAB[i].req;
        end

        // Directed: second reset, quiet port, count slot cycles (R3, R2)
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        chk("R1 row after mid-run reset", ref_row, 0);
        rst_n = 1'b1;
        busy_cyc = 0;
        cmd_cnt  = 0;
        while (edge_n < 70) begin
            @(negedge clk);
            if (ref_busy) busy_cyc++;
            if (ref_cmd)  cmd_cnt++;
        end
        chk("R3 busy cycles over three slots", busy_cyc, 3 * REF_CYC);
        chk("R2 refresh starts in 70 edges",   cmd_cnt, 3);
        chk("R4 row after three refreshes",    ref_row, 3);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule